// File: doc/BRIEF.md
# Tick-Driven Real-Time Counter with Dual Alarm Compare

This block keeps a free-running 32-bit time count for a chip that has a slow timebase. A single system clock drives all of it. A separate enable input pulses at the 32.768 kHz crystal rate. A programmable prescaler converts those pulses into a slower counting tick. The counter advances by one on each slow tick.

Two alarm compare registers sit next to the counter. A status word holds three event flags (alarm 0, alarm 1, periodic tick) and an interrupt enable for each one. Software clears an event flag by writing a 1 to its bit. A clock-select code starts or stops counting. A scratch word keeps software state, such as an epoch overflow count, beside the counter. One combined interrupt line reports any enabled event.

Software reaches every register over a simple word bus. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. The prescaler is a two-state machine with the states PS_HALT and PS_RUN:
- PS_HALT moves to PS_RUN on the first edge at which the clock-select register holds 0x03.
- PS_RUN returns to PS_HALT on the first edge at which it holds any other code.
- In PS_HALT the prescaler progress is held at zero.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and the counter does not advance.
- R2: While running, a slow tick occurs once every 2×(D+1) cycles with `tick_en` high, where D is the divider. The counter gains exactly 1 per slow tick. With D = 1023 this is once every 2048 enables.
- R3: The clock-select register (offset 0x1C, 8 bits) starts counting only with code 0x03. The first slow tick can occur no earlier than the third edge after the write. Any other code halts the prescaler and the counter from the second edge after the write on.
- R4: A write to offset 0x00 loads the counter and wins over a slow tick in the same cycle. The counter wraps from 0xFFFFFFFF to 0.
- R5: Alarm 0 sets its event when the counter advances to that value while its enable is set. Alarm 0 uses offset 0x04, event bit 0 and enable bit 2 of the status word. Alarm 1 uses offset 0x18, event bit 4 and enable bit 6.
- R6: Status bit 1 sets on every slow tick, whatever its enable (bit 3) holds, and never sets while halted.
- R7: A status write (offset 0x08) loads the enable bits 2, 3 and 6 with the written values. Writing 1 to event bit 0, 1 or 4 clears that bit, and writing 0 leaves it unchanged. An event that sets in the same cycle stays set. The unused status bits read 0.
- R8: `irq` is high exactly when some event bit and its matching enable bit are both set.
- R9: The scratch register at offset 0x40 is a full 32-bit read/write word that keeps its value across all other traffic.
- R10: The divider at offset 0x0C stores the low 16 bits of the written data and reads back with the upper bits zero.
- R11: Addresses outside the map read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at the crystal rate |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Combined interrupt: any event flag with its enable set |

## Verification
The hardest case to reach from the ports is an alarm match at the counter wrap. Only a counter load can reach it, because at real tick rates the count would take years to get there. The bench sets the divider to 0 so that a tick comes every second enable. It then loads 0xFFFFFFFE with alarm 0 at zero and counts the two ticks across the wrap. It also checks that a load that lands on a tick edge drops that tick. A behavioural reference model tracks every register on every clock. A long mixed phase of random writes, varying `tick_en` and reserved clock codes exercises the priority of a load over a tick and of an event set over a write-one clear.

// File: rtl/rtc_alarm_timer_pkg.sv
package rtc_alarm_timer_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int ALARM_N = 2;
    localparam int EVT_N   = ALARM_N + 1;   // alarms first, periodic tick last

    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ALARM0 = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_DIV    = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_ALARM1 = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CSEL   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_SCRTCH = 8'h40;

    localparam int CSEL_RUN = 3;

    typedef enum logic {
        PS_HALT = 1'b0,
        PS_RUN  = 1'b1
    } ps_state_t;

    // status bit position of each event flag (index: alarm0, alarm1, tick)
    function automatic int evt_pos(input int idx);
        case (idx)
            0:       return 0;
            1:       return 4;
            default: return 1;
        endcase
    endfunction

    // status bit position of each enable (index: alarm0, alarm1, tick)
    function automatic int ena_pos(input int idx);
        case (idx)
            0:       return 2;
            1:       return 6;
            default: return 3;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] alarm_ofs(input int idx);
        return (idx == 0) ? OFS_ALARM0 : OFS_ALARM1;
    endfunction

endpackage

// File: rtl/rtc_alarm_timer_prescaler.sv
module rtc_alarm_timer_prescaler
    import rtc_alarm_timer_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic             tick_en,
    input  logic [DIV_W-1:0] div,
    output logic             slow_tick,
    output logic             running
);

    ps_state_t        state_q, state_d;
    logic [DIV_W-1:0] half_q;
    logic             phase_q;
    logic             half_wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_HALT;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_HALT: if (run_req)  state_d = PS_RUN;
            PS_RUN:  if (!run_req) state_d = PS_HALT;
            default: state_d = PS_HALT;
        endcase
    end

    // half-period counter (>= so a smaller divider written mid-count takes effect at once)
    assign half_wrap = (half_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= '0;
            phase_q <= 1'b0;
        end else if (state_q == PS_HALT) begin
            half_q  <= '0;
            phase_q <= 1'b0;
        end else if (tick_en) begin
            if (half_wrap) begin
                half_q  <= '0;
                phase_q <= ~phase_q;
            end else begin
                half_q  <= half_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        slow_tick = 1'b0;
        running   = 1'b0;
        unique case (state_q)
            PS_HALT: begin
                slow_tick = 1'b0;
                running   = 1'b0;
            end
            PS_RUN: begin
                slow_tick = tick_en && half_wrap && phase_q;
                running   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rtc_alarm_timer_counter.sv
module rtc_alarm_timer_counter
    import rtc_alarm_timer_pkg::*;
#(
    parameter int CNT_W = DATA_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            slow_tick,
    input  logic                            load,
    input  logic [CNT_W-1:0]                load_val,
    input  logic [ALARM_N-1:0][CNT_W-1:0]   alarm_val,
    input  logic [ALARM_N-1:0]              alarm_en,
    output logic [CNT_W-1:0]                count,
    output logic [ALARM_N-1:0]              alarm_hit
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_inc;
    logic             advance;

    assign count_inc = count_q + 1'b1;
    assign advance   = slow_tick && !load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count_q <= '0;
        else if (load)    count_q <= load_val;
        else if (advance) count_q <= count_inc;
    end

    // equality test against the value the counter is about to take
    for (genvar gi = 0; gi < ALARM_N; gi++) begin : g_cmp
        assign alarm_hit[gi] = advance && alarm_en[gi] && (count_inc == alarm_val[gi]);
    end

    assign count = count_q;

endmodule

// File: rtl/rtc_alarm_timer_regs.sv
module rtc_alarm_timer_regs
    import rtc_alarm_timer_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int CSEL_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_wr,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    input  logic [DATA_W-1:0]                count,
    input  logic                             slow_tick,
    input  logic [ALARM_N-1:0]               alarm_hit,
    output logic                             cnt_load,
    output logic [ALARM_N-1:0][DATA_W-1:0]   alarm_val,
    output logic [DIV_W-1:0]                 div,
    output logic [CSEL_W-1:0]                csel,
    output logic [EVT_N-1:0]                 evt,
    output logic [EVT_N-1:0]                 ena
);

    logic [ALARM_N-1:0][DATA_W-1:0] alarm_q;
    logic [DIV_W-1:0]               div_q;
    logic [CSEL_W-1:0]              csel_q;
    logic [DATA_W-1:0]              scratch_q;
    logic [EVT_N-1:0]               evt_q, ena_q, evt_set;
    logic                           stat_wr;
    logic [DATA_W-1:0]              status_word;

    assign stat_wr  = bus_wr && (bus_addr == OFS_STATUS);
    assign cnt_load = bus_wr && (bus_addr == OFS_COUNT);
    assign evt_set  = {slow_tick, alarm_hit};

    for (genvar gi = 0; gi < ALARM_N; gi++) begin : g_alarm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alarm_q[gi] <= '0;
            else if (bus_wr && bus_addr == alarm_ofs(gi))
                alarm_q[gi] <= bus_wdata;
        end
    end

    // event flags: set wins over a write-one clear; enables load plainly
    for (genvar ge = 0; ge < EVT_N; ge++) begin : g_evt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                evt_q[ge] <= 1'b0;
                ena_q[ge] <= 1'b0;
            end else begin
                if (evt_set[ge])
                    evt_q[ge] <= 1'b1;
                else if (stat_wr && bus_wdata[evt_pos(ge)])
                    evt_q[ge] <= 1'b0;
                if (stat_wr)
                    ena_q[ge] <= bus_wdata[ena_pos(ge)];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q     <= '0;
            csel_q    <= '0;
            scratch_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_DIV)    div_q     <= bus_wdata[DIV_W-1:0];
            if (bus_addr == OFS_CSEL)   csel_q    <= bus_wdata[CSEL_W-1:0];
            if (bus_addr == OFS_SCRTCH) scratch_q <= bus_wdata;
        end
    end

    always_comb begin
        status_word = '0;
        for (int i = 0; i < EVT_N; i++) begin
            status_word[evt_pos(i)] = evt_q[i];
            status_word[ena_pos(i)] = ena_q[i];
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_COUNT:  bus_rdata = count;
            OFS_ALARM0: bus_rdata = alarm_q[0];
            OFS_ALARM1: bus_rdata = alarm_q[1];
            OFS_STATUS: bus_rdata = status_word;
            OFS_DIV:    bus_rdata = {{(DATA_W-DIV_W){1'b0}}, div_q};
            OFS_CSEL:   bus_rdata = {{(DATA_W-CSEL_W){1'b0}}, csel_q};
            OFS_SCRTCH: bus_rdata = scratch_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign alarm_val = alarm_q;
    assign div       = div_q;
    assign csel      = csel_q;
    assign evt       = evt_q;
    assign ena       = ena_q;

endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
    import rtc_alarm_timer_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int CSEL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic                           slow_tick;
    logic                           running;
    logic                           run_req;
    logic                           cnt_load;
    logic [DATA_W-1:0]              count_q;
    logic [ALARM_N-1:0]             alarm_hit;
    logic [ALARM_N-1:0][DATA_W-1:0] alarm_val;
    logic [DIV_W-1:0]               div;
    logic [CSEL_W-1:0]              csel;
    logic [EVT_N-1:0]               evt, ena;

    assign run_req = (csel == CSEL_W'(CSEL_RUN));

    rtc_alarm_timer_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_req   (run_req),
        .tick_en   (tick_en),
        .div       (div),
        .slow_tick (slow_tick),
        .running   (running)
    );

    rtc_alarm_timer_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .load      (cnt_load),
        .load_val  (bus_wdata),
        .alarm_val (alarm_val),
        .alarm_en  (ena[ALARM_N-1:0]),
        .count     (count_q),
        .alarm_hit (alarm_hit)
    );

    rtc_alarm_timer_regs #(.DIV_W(DIV_W), .CSEL_W(CSEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count_q),
        .slow_tick (slow_tick),
        .alarm_hit (alarm_hit),
        .cnt_load  (cnt_load),
        .alarm_val (alarm_val),
        .div       (div),
        .csel      (csel),
        .evt       (evt),
        .ena       (ena)
    );

    assign irq = |(evt & ena);

endmodule

// File: rtl/rtc_alarm_timer_chk.sv
module rtc_alarm_timer_chk
    import rtc_alarm_timer_pkg::*;
#(
    parameter int CSEL_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               slow_tick,
    input logic               cnt_load,
    input logic [DATA_W-1:0]  count,
    input logic [ALARM_N-1:0] alarm_hit,
    input logic [DATA_W-1:0]  alarm0,
    input logic [EVT_N-1:0]   evt,
    input logic [EVT_N-1:0]   ena,
    input logic [CSEL_W-1:0]  csel
);

    // R2: one slow tick moves the counter by exactly one
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && !cnt_load) |=> (count == $past(count) + 32'd1));

    // R2: a slow tick needs at least two enables, so it never repeats back to back
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |=> !slow_tick);

    // R3: a reserved clock code stops the ticks from the next cycle on
    a_r3_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (csel != CSEL_W'(CSEL_RUN)) |=> !slow_tick);

    // R4: a load takes the written value
    a_r4_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (count == $past(bus_wdata)));

    // R5: the alarm-0 event only rises with its enable on and the counter at the alarm value
    a_r5_alarm0_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt[0]) |-> ($past(ena[0]) && count == $past(alarm0)));

    // R7: writing one to the alarm-0 event clears it unless it is set again
    a_r7_w1c_alarm0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STATUS && bus_wdata[0] && !alarm_hit[0]) |=> !evt[0]);

    // R6: the tick event follows the slow tick
    a_r6_tick_event: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |=> evt[EVT_N-1]);

endmodule

bind rtc_alarm_timer rtc_alarm_timer_chk #(.CSEL_W(CSEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .slow_tick (slow_tick),
    .cnt_load  (cnt_load),
    .count     (count_q),
    .alarm_hit (alarm_hit),
    .alarm0    (alarm_val[0]),
    .evt       (evt),
    .ena       (ena),
    .csel      (csel)
);

// File: tb/rtc_alarm_timer_test.sv
module rtc_alarm_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R1";

    rtc_alarm_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_cnt, m_al0, m_al1, m_scr;
    logic [15:0] m_div;
    logic [7:0]  m_csel;
    int          m_half;
    bit          m_phase, m_run;
    bit          m_ev0, m_ev1, m_evt, m_en0, m_en1, m_ent;

    task automatic model_reset();
        m_cnt = 0; m_al0 = 0; m_al1 = 0; m_scr = 0; m_div = 0; m_csel = 0;
        m_half = 0; m_phase = 0; m_run = 0;
        m_ev0 = 0; m_ev1 = 0; m_evt = 0; m_en0 = 0; m_en1 = 0; m_ent = 0;
    endtask

    initial model_reset();

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] st;
        st = '0;
        st[0] = m_ev0; st[1] = m_evt; st[2] = m_en0; st[3] = m_ent;
        st[4] = m_ev1; st[6] = m_en1;
        case (a)
            8'h00: return m_cnt;
            8'h04: return m_al0;
            8'h08: return st;
            8'h0C: return {16'h0, m_div};
            8'h18: return m_al1;
            8'h1C: return {24'h0, m_csel};
            8'h40: return m_scr;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit          wrap, slow, ld, sw, hit0, hit1, run_old;
            logic [31:0] nxt;
            run_old = m_run;
            wrap = (m_half >= int'(m_div));
            slow = run_old && tick_en && wrap && m_phase;
            if (!run_old) begin m_half = 0; m_phase = 0; end
            else if (tick_en) begin
                if (wrap) begin m_half = 0; m_phase = !m_phase; end
                else m_half = m_half + 1;
            end
            m_run = (m_csel == 8'h03);
            ld = bus_wr && bus_addr == 8'h00;
            sw = bus_wr && bus_addr == 8'h08;
            nxt = m_cnt + 32'd1;
            hit0 = slow && !ld && m_en0 && nxt == m_al0;
            hit1 = slow && !ld && m_en1 && nxt == m_al1;
            if (ld) m_cnt = bus_wdata;
            else if (slow) m_cnt = nxt;
            if (hit0) m_ev0 = 1; else if (sw && bus_wdata[0]) m_ev0 = 0;
            if (hit1) m_ev1 = 1; else if (sw && bus_wdata[4]) m_ev1 = 0;
            if (slow) m_evt = 1; else if (sw && bus_wdata[1]) m_evt = 0;
            if (sw) begin m_en0 = bus_wdata[2]; m_ent = bus_wdata[3]; m_en1 = bus_wdata[6]; end
            if (bus_wr) begin
                case (bus_addr)
                    8'h04: m_al0 = bus_wdata;
                    8'h18: m_al1 = bus_wdata;
                    8'h0C: m_div = bus_wdata[15:0];
                    8'h1C: m_csel = bus_wdata[7:0];
                    8'h40: m_scr = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // every clock: read data of the current address and irq against the model (R8 for irq)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] e;
            bit          ei;
            e  = model_read(bus_addr);
            ei = (m_ev0 && m_en0) || (m_ev1 && m_en1) || (m_evt && m_ent);
            check(bus_rdata === e, cur_req, "model rdata", bus_rdata, e);
            check(irq === ei, "R8", "model irq", {31'h0, irq}, {31'h0, ei});
        end
    end

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc(1);
        bus_wr = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] mask,
                          input logic [31:0] exp, input string req);
        bus_addr = a;
        #1;
        check((bus_rdata & mask) === exp, req, $sformatf("read %h", a), bus_rdata & mask, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] c, prev;
        int          t1, t2, changes, cyc_n;
        logic [7:0]  alist [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h1C, 8'h40, 8'h24};

        cyc(3);
        rst_n = 1;
        cyc(1);

        // R1: everything zero after reset, counter stopped
        cur_req = "R1";
        tick_en = 1;
        foreach (alist[i]) rd_chk(alist[i], 32'hFFFF_FFFF, 32'h0, "R1");
        check(irq === 1'b0, "R1", "irq after reset", {31'h0, irq}, 32'h0);
        cyc(10);
        rd_chk(8'h00, 32'hFFFF_FFFF, 32'h0, "R1");

        // R3: start with code 3 and divider 0; first tick on the third edge after the write
        cur_req = "R3";
        bus_addr = 8'h00;
        wr(8'h1C, 32'h3);
        cyc(2);
        rd_chk(8'h00, 32'hFFFF_FFFF, 32'h0, "R3");
        cyc(1);
        rd_chk(8'h00, 32'hFFFF_FFFF, 32'h1, "R3");
        cur_req = "R2";
        cyc(2);
        rd_chk(8'h00, 32'hFFFF_FFFF, 32'h2, "R2");
        cyc(4);
        rd_chk(8'h00, 32'hFFFF_FFFF, 32'h4, "R2");

        // R4 / R5 / R8: alarm 0 at zero, counter loaded just below the wrap
        cur_req = "R4";
        wr(8'h08, 32'h0000_0017);          // clear events, enable alarm 0 only
        wr(8'h00, 32'hFFFF_FFFE);
        cyc(6);
        rd_chk(8'h00, 32'hFFFF_FFFF, 32'h1, "R4");
        rd_chk(8'h08, 32'h0000_0005, 32'h5, "R5");
        check(irq === 1'b1, "R8", "irq on alarm 0", {31'h0, irq}, 32'h1);

        // R7: writing zero keeps the event, writing one clears it
        cur_req = "R7";
        wr(8'h08, 32'h0000_0004);
        rd_chk(8'h08, 32'h0000_0005, 32'h5, "R7");
        wr(8'h08, 32'h0000_0005);
        rd_chk(8'h08, 32'h0000_0005, 32'h4, "R7");
        check(irq === 1'b0, "R8", "irq after clear", {31'h0, irq}, 32'h0);

        // R3 / R6: a reserved code freezes the counter and the tick event
        cur_req = "R3";
        wr(8'h1C, 32'h2);
        cyc(2);
        wr(8'h08, 32'h0000_0002);          // clear the tick event, all enables off
        bus_addr = 8'h00;
        #1 c = bus_rdata;
        cyc(12);
        rd_chk(8'h00, 32'hFFFF_FFFF, c, "R3");
        rd_chk(8'h08, 32'h0000_0002, 32'h0, "R6");

        // R6 / R8: tick event with its enable raises irq
        cur_req = "R6";
        wr(8'h1C, 32'h3);
        wr(8'h08, 32'h0000_0008);
        cyc(5);
        rd_chk(8'h08, 32'h0000_000A, 32'hA, "R6");
        check(irq === 1'b1, "R8", "irq on tick", {31'h0, irq}, 32'h1);

        // R5: alarm 1 with its own bits
        cur_req = "R5";
        wr(8'h08, 32'h0000_0013);          // clear flags, enables off
        bus_addr = 8'h00;
        #1 c = bus_rdata;
        wr(8'h18, c + 32'd4);
        wr(8'h08, 32'h0000_0040);
        cyc(14);
        rd_chk(8'h08, 32'h0000_0050, 32'h50, "R5");
        check(irq === 1'b1, "R8", "irq on alarm 1", {31'h0, irq}, 32'h1);
        wr(8'h08, 32'h0000_0013);

        // R9 / R10 / R11: scratch, divider width, unmapped space
        cur_req = "R9";
        wr(8'h40, 32'hA5C3_1E96);
        wr(8'h04, 32'h1234_5678);
        wr(8'h24, 32'hFFFF_FFFF);
        rd_chk(8'h40, 32'hFFFF_FFFF, 32'hA5C3_1E96, "R9");
        rd_chk(8'h24, 32'hFFFF_FFFF, 32'h0, "R11");
        rd_chk(8'h04, 32'hFFFF_FFFF, 32'h1234_5678, "R11");
        cur_req = "R10";
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_chk(8'h0C, 32'hFFFF_FFFF, 32'h0000_FFFF, "R10");
        wr(8'h1C, 32'h0000_01FF);
        rd_chk(8'h1C, 32'hFFFF_FFFF, 32'h0000_00FF, "R3");
        wr(8'h1C, 32'h3);

        // R2: divider 1023 gives one count per 2048 enables
        cur_req = "R2";
        wr(8'h0C, 32'd1023);
        bus_addr = 8'h00;
        #1 prev = bus_rdata;
        changes = 0; t1 = 0; t2 = 0; cyc_n = 0;
        while (changes < 3 && cyc_n < 8000) begin
            cyc(1);
            cyc_n++;
            if (bus_rdata != prev) begin
                changes++;
                prev = bus_rdata;
                if (changes == 2) t1 = cyc_n;
                if (changes == 3) t2 = cyc_n;
            end
        end
        check(t2 - t1 == 2048, "R2", "cycles per count at divider 1023", t2 - t1, 32'd2048);
        wr(8'h0C, 32'd0);

        // mixed traffic against the model
        cur_req = "R4";
        for (int k = 0; k < 4000; k++) begin
            logic [7:0]  a;
            logic [31:0] d;
            tick_en = ($urandom % 4) != 0;
            a = alist[$urandom % 8];
            if (($urandom % 6) == 0) begin
                case (a)
                    8'h0C: d = $urandom % 3;
                    8'h1C: d = (($urandom % 8) == 0) ? 32'h1 : 32'h3;
                    8'h04, 8'h18: d = m_cnt + ($urandom % 6);
                    8'h00: d = (($urandom % 2) == 0) ? 32'hFFFF_FFFD : $urandom;
                    default: d = $urandom;
                endcase
                wr(a, d);
            end else begin
                bus_addr = alist[$urandom % 8];
                cyc(1);
            end
        end

        tick_en = 0;
        cyc(2);
        finish_run();
    end

endmodule